// File: doc/BRIEF.md
# Millisecond Real-Time Counter with Shadow Seconds

This block keeps wall-clock time as a seconds count and a milliseconds count. It advances from a slow timebase tick that comes from an always-on 32 kHz source, so time continues through low-power states. A fractional accumulator turns the tick stream into millisecond steps. With the default `TICK_HZ = 32768`, exactly 1000 steps occur for every 32768 ticks. The milliseconds count runs from 0 to 999. When it wraps, the seconds count increments.

Software reads the block through a small register port with read and write strobes, a byte address and a data word. A read of the milliseconds register also copies the live seconds value into a shadow register on the same clock edge. Software therefore reads milliseconds first and the shadow second, and gets a matched pair. It forms the timestamp as shadow × 1000 + milliseconds. There is only one shadow register, so two software agents that interleave their reads will corrupt each other's pairing. Writing the live seconds register loads a new seconds value and restarts the current second at zero.

Top module: `rtc_ms_core`

## Requirements
- R1: After reset, the seconds count, the shadow, the milliseconds count, the accumulator and the read data are all zero.
- R2: Each cycle with `tick_i` high adds MS_PER_S to an accumulator. When the sum reaches TICK_HZ, TICK_HZ is subtracted and milliseconds advance by one. After N ticks from a cleared state, milliseconds equal floor(N·MS_PER_S/TICK_HZ), up to the first wrap.
- R3: Milliseconds never leave 0..MS_PER_S-1. A step taken at MS_PER_S-1 sets milliseconds to 0 and increments seconds by one.
- R4: A read at byte address 0x10 returns the milliseconds value from before that clock edge. On the same edge, the shadow is loaded with the seconds value from before that edge.
- R5: A read at 0x0C returns the shadow. The shadow changes only on a read of 0x10. A seconds advance or a read of 0x08 leaves it unchanged.
- R6: A write at 0x08 loads seconds from `wdata_i` and clears both milliseconds and the accumulator. A read at 0x08 returns the live seconds value.
- R7: Writes to 0x0C, to 0x10 and to any other address change no state.
- R8: Read data is registered and valid in the cycle after `rd_en_i`. It holds until the next read. Addresses other than 0x08, 0x0C and 0x10 read as 0.
- R9: A seconds write in the same cycle as a tick takes priority: that tick is discarded.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Register clock |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously inside the block |
| tick_i | input | 1 | One-cycle strobe per timebase tick, already synchronous to `clk` |
| rd_en_i | input | 1 | Read strobe |
| wr_en_i | input | 1 | Write strobe |
| addr_i | input | ADDR_W (5) | Byte address |
| wdata_i | input | DATA_W (32) | Write data |
| rdata_o | output | DATA_W (32) | Registered read data |

## Verification
Every result appears one edge after the cycle that causes it. Read data is valid after the edge that ends the read cycle. A tick or a seconds write shows in the counters after its edge, so a read issued in the following cycle returns it. The shadow is loaded on the same edge as the milliseconds read. The bench drives each stimulus for exactly one cycle starting at a falling edge and samples `rdata_o` at the next falling edge. Its reference model applies the read first and then the write or tick, using the state from before the edge. This ordering covers the case where a milliseconds read and a wrapping tick fall in the same cycle.

// File: rtl/rtc_ms_pkg.sv
package rtc_ms_pkg;
  localparam logic [15:0] OFS_SEC = 16'h0008;
  localparam logic [15:0] OFS_SHD = 16'h000c;
  localparam logic [15:0] OFS_MS  = 16'h0010;

  typedef enum logic [1:0] {SEL_NONE, SEL_SEC, SEL_SHD, SEL_MS} rtc_sel_e;

  function automatic rtc_sel_e rtc_decode(input logic [15:0] a);
    case (a)
      OFS_SEC: rtc_decode = SEL_SEC;
      OFS_SHD: rtc_decode = SEL_SHD;
      OFS_MS:  rtc_decode = SEL_MS;
      default: rtc_decode = SEL_NONE;
    endcase
  endfunction
endpackage

// File: rtl/rtc_rst_sync.sv
module rtc_rst_sync (
  input  logic clk,
  input  logic rst_n,
  output logic rst_sync_n
);
  logic [1:0] sync_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) sync_q <= 2'b00;
    else        sync_q <= {sync_q[0], 1'b1};
  end

  assign rst_sync_n = sync_q[1];
endmodule

// File: rtl/rtc_frac_step.sv
module rtc_frac_step #(
  parameter int TICK_HZ  = 32768,
  parameter int MS_PER_S = 1000
) (
  input  logic clk,
  input  logic rst_n,
  input  logic tick_i,
  input  logic clear_i,
  output logic step_o
);
  localparam int ACC_W = $clog2(TICK_HZ + MS_PER_S + 1);

  logic [ACC_W-1:0] acc_q, acc_d, sum;
  logic             carry;

  always_comb begin
    sum    = acc_q + ACC_W'(MS_PER_S);
    carry  = (sum >= ACC_W'(TICK_HZ));
    step_o = tick_i && !clear_i && carry;
    acc_d  = acc_q;
    if (clear_i)     acc_d = '0;
    else if (tick_i) acc_d = carry ? (sum - ACC_W'(TICK_HZ)) : sum;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) acc_q <= '0;
    else        acc_q <= acc_d;
  end

  // R2: remainder stays below one full second of ticks
  p_acc_range_r2: assert property (@(posedge clk) disable iff (!rst_n)
    acc_q < ACC_W'(TICK_HZ));

  // R2: every accepted tick moves the remainder
  p_acc_moves_r2: assert property (@(posedge clk) disable iff (!rst_n)
    (tick_i && !clear_i) |=> (acc_q != $past(acc_q)));

  // R6: a clear empties the accumulator
  p_acc_clear_r6: assert property (@(posedge clk) disable iff (!rst_n)
    clear_i |=> (acc_q == '0));
endmodule

// File: rtl/rtc_time_cnt.sv
module rtc_time_cnt #(
  parameter int MS_PER_S = 1000,
  parameter int DATA_W   = 32
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              step_i,
  input  logic              set_i,
  input  logic [DATA_W-1:0] set_val_i,
  output logic [DATA_W-1:0] sec_o,
  output logic [DATA_W-1:0] ms_o
);
  localparam int MS_W = $clog2(MS_PER_S);

  logic [MS_W-1:0]   ms_q, ms_d;
  logic [DATA_W-1:0] sec_q, sec_d;
  logic              ms_last;

  always_comb begin
    ms_last = (ms_q == MS_W'(MS_PER_S - 1));
    ms_d    = ms_q;
    sec_d   = sec_q;
    if (set_i) begin
      ms_d  = '0;
      sec_d = set_val_i;
    end else if (step_i) begin
      ms_d  = ms_last ? '0 : ms_q + 1'b1;
      sec_d = ms_last ? sec_q + 1'b1 : sec_q;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      ms_q  <= '0;
      sec_q <= '0;
    end else begin
      ms_q  <= ms_d;
      sec_q <= sec_d;
    end
  end

  assign sec_o = sec_q;
  assign ms_o  = DATA_W'(ms_q);

  p_ms_range_r3: assert property (@(posedge clk) disable iff (!rst_n)
    ms_o < DATA_W'(MS_PER_S));

  p_wrap_r3: assert property (@(posedge clk) disable iff (!rst_n)
    (step_i && !set_i && ms_o == DATA_W'(MS_PER_S - 1))
      |=> (ms_o == '0 && sec_o == $past(sec_o) + 1'b1));

  p_set_r6: assert property (@(posedge clk) disable iff (!rst_n)
    set_i |=> (ms_o == '0 && sec_o == $past(set_val_i)));

  p_idle_r7: assert property (@(posedge clk) disable iff (!rst_n)
    (!set_i && !step_i) |=> ($stable(ms_o) && $stable(sec_o)));
endmodule

// File: rtl/rtc_regs.sv
module rtc_regs
  import rtc_ms_pkg::*;
#(
  parameter int ADDR_W = 5,
  parameter int DATA_W = 32
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              rd_en_i,
  input  logic              wr_en_i,
  input  logic [ADDR_W-1:0] addr_i,
  input  logic [DATA_W-1:0] sec_i,
  input  logic [DATA_W-1:0] ms_i,
  output logic              set_o,
  output logic [DATA_W-1:0] rdata_o
);
  rtc_sel_e          sel;
  logic              cap_en;
  logic [DATA_W-1:0] shd_q, shd_d, rd_q, rd_d, rd_mux;

  always_comb begin
    sel    = rtc_decode(16'(addr_i));
    set_o  = wr_en_i && (sel == SEL_SEC);
    cap_en = rd_en_i && (sel == SEL_MS);
    case (sel)
      SEL_SEC: rd_mux = sec_i;
      SEL_SHD: rd_mux = shd_q;
      SEL_MS:  rd_mux = ms_i;
      default: rd_mux = '0;
    endcase
    shd_d = cap_en  ? sec_i  : shd_q;
    rd_d  = rd_en_i ? rd_mux : rd_q;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      shd_q <= '0;
      rd_q  <= '0;
    end else begin
      shd_q <= shd_d;
      rd_q  <= rd_d;
    end
  end

  assign rdata_o = rd_q;

  p_capture_r4: assert property (@(posedge clk) disable iff (!rst_n)
    cap_en |=> (shd_q == $past(sec_i) && rdata_o == $past(ms_i)));

  p_shadow_hold_r5: assert property (@(posedge clk) disable iff (!rst_n)
    !cap_en |=> $stable(shd_q));

  p_rdata_hold_r8: assert property (@(posedge clk) disable iff (!rst_n)
    !rd_en_i |=> $stable(rdata_o));
endmodule

// File: rtl/rtc_ms_core.sv
module rtc_ms_core #(
  parameter int TICK_HZ  = 32768,
  parameter int MS_PER_S = 1000,
  parameter int ADDR_W   = 5,
  parameter int DATA_W   = 32
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              tick_i,
  input  logic              rd_en_i,
  input  logic              wr_en_i,
  input  logic [ADDR_W-1:0] addr_i,
  input  logic [DATA_W-1:0] wdata_i,
  output logic [DATA_W-1:0] rdata_o
);
  logic              rst_sync_n, step, set;
  logic [DATA_W-1:0] sec, ms;

  rtc_rst_sync u_rst (
    .clk       (clk),
    .rst_n     (rst_n),
    .rst_sync_n(rst_sync_n)
  );

  rtc_frac_step #(.TICK_HZ(TICK_HZ), .MS_PER_S(MS_PER_S)) u_step (
    .clk    (clk),
    .rst_n  (rst_sync_n),
    .tick_i (tick_i),
    .clear_i(set),
    .step_o (step)
  );

  rtc_time_cnt #(.MS_PER_S(MS_PER_S), .DATA_W(DATA_W)) u_cnt (
    .clk      (clk),
    .rst_n    (rst_sync_n),
    .step_i   (step),
    .set_i    (set),
    .set_val_i(wdata_i),
    .sec_o    (sec),
    .ms_o     (ms)
  );

  rtc_regs #(.ADDR_W(ADDR_W), .DATA_W(DATA_W)) u_regs (
    .clk    (clk),
    .rst_n  (rst_sync_n),
    .rd_en_i(rd_en_i),
    .wr_en_i(wr_en_i),
    .addr_i (addr_i),
    .sec_i  (sec),
    .ms_i   (ms),
    .set_o  (set),
    .rdata_o(rdata_o)
  );

  // R9: a same-cycle write wins over a tick, so no step survives it
  p_write_wins_r9: assert property (@(posedge clk) disable iff (!rst_sync_n)
    set |-> !step);
endmodule

// File: tb/sim_rtc_ms_core.sv
module sim_rtc_ms_core;
  localparam int TICK_HZ = 2500;
  localparam int MSPS    = 1000;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        tick = 1'b0, rd = 1'b0, wr = 1'b0;
  logic [4:0]  addr = '0;
  logic [31:0] wdata = '0;
  logic [31:0] rdata;

  int checks = 0, errors = 0;
  bit done = 1'b0;

  // independent reference state
  longint acc_m = 0, ms_m = 0, sec_m = 0, shd_m = 0, rd_m = 0;

  always #10 clk = ~clk;

  rtc_ms_core #(.TICK_HZ(TICK_HZ), .MS_PER_S(MSPS)) u0 (
    .clk(clk), .rst_n(rst_n), .tick_i(tick), .rd_en_i(rd), .wr_en_i(wr),
    .addr_i(addr), .wdata_i(wdata), .rdata_o(rdata)
  );

  task automatic chk(input string req, input longint got, input longint exp);
    checks++;
    if (got != exp) begin
      errors++;
      $display("FAIL %s actual %0d expected %0d", req, got, exp);
    end
  endtask

  // one bus cycle; model uses pre-edge state: read first, then write or tick
  task automatic cyc(input bit t, input bit r, input bit w,
                     input logic [4:0] a, input logic [31:0] d);
    @(negedge clk);
    tick = t; rd = r; wr = w; addr = a; wdata = d;
    if (r) begin
      case (a)
        5'h08:   rd_m = sec_m;
        5'h0c:   rd_m = shd_m;
        5'h10:   begin rd_m = ms_m; shd_m = sec_m; end
        default: rd_m = 0;
      endcase
    end
    if (w && a == 5'h08) begin
      sec_m = d; ms_m = 0; acc_m = 0;
    end else if (t) begin
      acc_m += MSPS;
      if (acc_m >= TICK_HZ) begin
        acc_m -= TICK_HZ;
        if (ms_m == MSPS - 1) begin ms_m = 0; sec_m = (sec_m + 1) & 32'hffffffff; end
        else ms_m++;
      end
    end
    @(negedge clk);
    tick = 0; rd = 0; wr = 0;
  endtask

  task automatic ticks(input int n);
    for (int i = 0; i < n; i++) cyc(1, 0, 0, 5'h00, 0);
  endtask

  task automatic rd_chk(input string req, input logic [4:0] a);
    cyc(0, 1, 0, a, 0);
    chk(req, rdata, rd_m);
  endtask

  task automatic t_reset;
    chk("R1 rdata after reset", rdata, 0);
    rd_chk("R1 seconds", 5'h08);
    rd_chk("R1 shadow", 5'h0c);
    rd_chk("R1 ms", 5'h10);
  endtask

  task automatic t_advance;
    ticks(5);
    rd_chk("R2 ms after 5 ticks", 5'h10);
    chk("R2 ms value 5 ticks", rdata, 2);
    ticks(7);
    rd_chk("R2 ms after 12 ticks", 5'h10);
    chk("R2 ms value 12 ticks", rdata, 4);
  endtask

  task automatic t_wrap;
    cyc(0, 0, 1, 5'h08, 41);
    rd_chk("R6 ms cleared", 5'h10);
    chk("R6 ms zero", rdata, 0);
    rd_chk("R6 seconds loaded", 5'h08);
    chk("R6 seconds 41", rdata, 41);
    ticks(2498);
    rd_chk("R3 ms at 999", 5'h10);
    chk("R3 ms value 999", rdata, 999);
    ticks(2);
    rd_chk("R3 ms wrapped", 5'h10);
    chk("R3 ms 0", rdata, 0);
    rd_chk("R3 seconds incremented", 5'h08);
    chk("R3 seconds 42", rdata, 42);
  endtask

  task automatic t_shadow;
    rd_chk("R4 ms read", 5'h10);
    ticks(2500);
    rd_chk("R5 live seconds", 5'h08);
    chk("R5 live 43", rdata, 43);
    rd_chk("R5 shadow kept", 5'h0c);
    chk("R5 shadow 42", rdata, 42);
    rd_chk("R4 ms read again", 5'h10);
    rd_chk("R4 shadow recaptured", 5'h0c);
    chk("R4 shadow 43", rdata, 43);
  endtask

  task automatic t_ignored;
    cyc(0, 0, 1, 5'h0c, 777);
    cyc(0, 0, 1, 5'h10, 555);
    cyc(0, 0, 1, 5'h14, 9);
    rd_chk("R7 shadow after writes", 5'h0c);
    rd_chk("R7 ms after writes", 5'h10);
    rd_chk("R7 seconds after writes", 5'h08);
    rd_chk("R8 unmapped 0x00", 5'h00);
    rd_chk("R8 unmapped 0x14", 5'h14);
    cyc(0, 0, 0, 5'h08, 0);
    cyc(0, 0, 0, 5'h08, 0);
    chk("R8 rdata held", rdata, 0);
  endtask

  task automatic t_collide;
    ticks(3);
    cyc(1, 0, 1, 5'h08, 100);
    ticks(2);
    rd_chk("R9 ms after write+tick", 5'h10);
    chk("R9 ms 0", rdata, 0);
    ticks(1);
    rd_chk("R9 ms after third tick", 5'h10);
    chk("R9 ms 1", rdata, 1);
    rd_chk("R9 seconds", 5'h08);
  endtask

  task automatic t_coherent;
    cyc(0, 0, 1, 5'h08, 7);
    ticks(2499);
    cyc(1, 1, 0, 5'h10, 0);
    chk("R4 ms at wrapping edge", rdata, 999);
    rd_chk("R4 shadow at wrapping edge", 5'h0c);
    chk("R4 shadow 7", rdata, 7);
    rd_chk("R3 ms after wrap", 5'h10);
    rd_chk("R3 seconds 8", 5'h08);
    chk("R3 seconds value 8", rdata, 8);
  endtask

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    repeat (3) @(negedge clk);
    t_reset();
    t_advance();
    t_wrap();
    t_shadow();
    t_ignored();
    t_collide();
    t_coherent();
    done = 1'b1;
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    repeat (150000) @(posedge clk);
    if (!done) begin
      checks++;
      errors++;
      $display("FAIL watchdog actual 0 expected 1");
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end
endmodule